// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block picks one interrupt line to serve out of a set of pending lines, and decides whether that line should interrupt the handler already running. Each line has its own 6-bit urgency value, where a smaller number means more urgent. A global grouping selector splits each value into two parts. The upper bits form a group level, which decides preemption. The lower bits form a sub-level, which only orders requests that share a group level.

Software loads each line's urgency through a simple one-line write port. Peripherals drive the pending bits, and per-line enable bits gate them. The core reports whether a handler is running and its urgency value. The block then registers three results: the index of the winning line, a valid flag, and a flag asking the core to preempt. Every input is a plain control pin, so the block has no back-pressure.

Top module: `prio_group_arbiter`

## Requirements
- R1: After reset, every line's urgency value is 0, and win_valid_o, win_idx_o and preempt_o are all 0.
- R2: When prio_wr_en is high at a clock edge, the value on prio_wr_data is stored for line prio_wr_idx. The new value is used from the next clock edge onward.
- R3: A line can win only if its pending bit and its enable bit are both 1. When no line qualifies, win_valid_o is 0 and preempt_o is 0.
- R4: Among the qualifying lines, the line with the numerically smallest group level wins. If several lines share that group level, the one with the smallest sub-level wins.
- R5: When two qualifying lines have the same group level and the same sub-level, the lower line index wins.
- R6: The grouping selector group_sel_i gives the number of sub-level bits. The values 0 and 1 give 0 bits. A value g from 2 to 7 gives g-1 bits. The sub-level is the low bits of the 6-bit value, and the group level is the remaining high bits.
- R7: While run_active_i is 1, preempt_o is 1 only if the winner's group level is strictly smaller than the group level of run_prio_i. Both group levels use the current grouping selector.
- R8: While run_active_i is 0, preempt_o equals win_valid_o.
- R9: All three outputs are registered. They reflect the inputs and the stored urgency values as they were at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_LINES | Pending bit per line |
| en_i | input | NUM_LINES | Enable bit per line |
| prio_wr_en | input | 1 | Urgency write strobe |
| prio_wr_idx | input | IDX_W | Line selected by the write |
| prio_wr_data | input | 6 | Urgency value to store |
| group_sel_i | input | 3 | Grouping selector |
| run_active_i | input | 1 | A handler is running |
| run_prio_i | input | 6 | Urgency value of the running handler |
| win_idx_o | output | IDX_W | Index of the winning line |
| win_valid_o | output | 1 | A qualifying line exists |
| preempt_o | output | 1 | The winner should preempt the running handler |

## Verification
Several stimulus patterns are used, and each one isolates a different rule.

- **All urgency values equal.** The winner can only come from the index tie-break, so this tests that rule alone.
- **Random urgency values.** These exercise the ordering by group level and then sub-level.
- **Pending without enable, and enable without pending.** These show that both bits are needed for a line to qualify.
- **Grouping selector swept 0 to 7, running urgency held fixed.** Whether preemption happens depends only on how the value is split. A fixed-compare design would give a different answer at some selector value.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int PRIO_W = 6;
  localparam int GSEL_W = 3;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [GSEL_W-1:0] gsel_t;

  // number of low bits that form the sub-level
  function automatic logic [2:0] sub_bits(input gsel_t g);
    if (g <= gsel_t'(1)) return 3'd0;
    return 3'(g - gsel_t'(1));
  endfunction

  function automatic prio_t group_of(input prio_t p, input gsel_t g);
    return p >> sub_bits(g);
  endfunction
endpackage

// File: rtl/prio_arb_regs.sv
module prio_arb_regs
  import prio_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  prio_t                        wr_data,
  output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_o[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        prio_o[i] <= wr_data;
    end
  end
endmodule

// File: rtl/prio_arb_select.sv
module prio_arb_select
  import prio_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]             req_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                             found_o,
  output logic [IDX_W-1:0]                 idx_o,
  output prio_t                            prio_o
);
  // group occupies the high bits, so a full-value compare orders by
  // group first and sub-level second; strict < keeps the lower index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req_i[i] && (!found_o || (prio_i[i] < prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_arb_preempt.sv
module prio_arb_preempt
  import prio_arb_pkg::*;
(
  input  logic  found_i,
  input  prio_t win_prio_i,
  input  gsel_t gsel_i,
  input  logic  run_active_i,
  input  prio_t run_prio_i,
  output logic  preempt_o
);
  prio_t win_grp, run_grp;

  always_comb begin
    win_grp   = group_of(win_prio_i, gsel_i);
    run_grp   = group_of(run_prio_i, gsel_i);
    preempt_o = found_i && (!run_active_i || (win_grp < run_grp));
  end
endmodule

// File: rtl/prio_group_arbiter.sv
module prio_group_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic                 prio_wr_en,
  input  logic [IDX_W-1:0]     prio_wr_idx,
  input  logic [5:0]           prio_wr_data,
  input  logic [2:0]           group_sel_i,
  input  logic                 run_active_i,
  input  logic [5:0]           run_prio_i,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 win_valid_o,
  output logic                 preempt_o
);
  logic [NUM_LINES-1:0][PRIO_W-1:0] line_prio;
  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;
  prio_t            sel_prio;
  logic             sel_preempt;

  prio_arb_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prio_wr_en),
    .wr_idx  (prio_wr_idx),
    .wr_data (prio_wr_data),
    .prio_o  (line_prio)
  );

  prio_arb_select #(.NUM_LINES(NUM_LINES)) u_select (
    .req_i   (pend_i & en_i),
    .prio_i  (line_prio),
    .found_o (sel_found),
    .idx_o   (sel_idx),
    .prio_o  (sel_prio)
  );

  prio_arb_preempt u_preempt (
    .found_i      (sel_found),
    .win_prio_i   (sel_prio),
    .gsel_i       (group_sel_i),
    .run_active_i (run_active_i),
    .run_prio_i   (run_prio_i),
    .preempt_o    (sel_preempt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_idx_o   <= '0;
      win_valid_o <= 1'b0;
      preempt_o   <= 1'b0;
    end else begin
      win_idx_o   <= sel_idx;
      win_valid_o <= sel_found;
      preempt_o   <= sel_preempt;
    end
  end
endmodule

// File: rtl/prio_group_arbiter_chk.sv
module prio_group_arbiter_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] pend_i,
  input logic [NUM_LINES-1:0] en_i,
  input logic                 run_active_i,
  input logic [IDX_W-1:0]     win_idx_o,
  input logic                 win_valid_o,
  input logic                 preempt_o
);
  logic [NUM_LINES-1:0] req_q;
  always_ff @(posedge clk) req_q <= pend_i & en_i;

  // R3
  winner_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> req_q[win_idx_o]);

  // R3
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_i & en_i)) |=> !win_valid_o);

  // R3
  any_req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_i & en_i)) |=> win_valid_o);

  // R7
  preempt_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> win_valid_o);

  // R8
  no_handler_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_active_i |=> (preempt_o == win_valid_o));
endmodule

bind prio_group_arbiter prio_group_arbiter_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pend_i       (pend_i),
  .en_i         (en_i),
  .run_active_i (run_active_i),
  .win_idx_o    (win_idx_o),
  .win_valid_o  (win_valid_o),
  .preempt_o    (preempt_o)
);

// File: tb/prio_group_arbiter_test.sv
`timescale 1ns/1ps
module prio_group_arbiter_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend_i = '0;
  logic [N-1:0]  en_i = '0;
  logic          prio_wr_en = 1'b0;
  logic [IW-1:0] prio_wr_idx = '0;
  logic [5:0]    prio_wr_data = '0;
  logic [2:0]    group_sel_i = '0;
  logic          run_active_i = 1'b0;
  logic [5:0]    run_prio_i = '0;
  logic [IW-1:0] win_idx_o;
  logic          win_valid_o;
  logic          preempt_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  int model_prio [N];
  int exp_idx = 0;
  bit exp_valid = 0;
  bit exp_pre = 0;
  bit exp_ready = 0;

  always #2.5 clk = ~clk;

  prio_group_arbiter #(.NUM_LINES(N)) uut (.*);

  // reference: behavioural, computed from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) model_prio[i] = 0;
      exp_idx = 0; exp_valid = 0; exp_pre = 0;
    end else begin
      int best, bidx, sb, d;
      best = 1000; bidx = 0;
      for (int i = 0; i < N; i++)
        if (pend_i[i] && en_i[i] && model_prio[i] < best) begin
          best = model_prio[i]; bidx = i;
        end
      exp_valid = (best != 1000);
      exp_idx = exp_valid ? bidx : 0;
      sb = (group_sel_i <= 1) ? 0 : int'(group_sel_i) - 1;
      d = 1;
      for (int k = 0; k < sb; k++) d = d * 2;
      if (!exp_valid) exp_pre = 0;
      else if (!run_active_i) exp_pre = 1;
      else exp_pre = (best / d) < (int'(run_prio_i) / d);
      if (prio_wr_en) model_prio[prio_wr_idx] = prio_wr_data;
    end
    exp_ready = 1;
  end

  always @(negedge clk) begin
    cycles++;
    if (exp_ready) begin
      checks++;
      if (win_valid_o !== exp_valid) begin
        errors++;
        $display("FAIL %s R3 R9 valid: got %0b exp %0b", tag, win_valid_o, exp_valid);
      end
      checks++;
      if (exp_valid && win_idx_o !== IW'(exp_idx)) begin
        errors++;
        $display("FAIL %s R4 R5 idx: got %0d exp %0d", tag, win_idx_o, exp_idx);
      end
      checks++;
      if (preempt_o !== exp_pre) begin
        errors++;
        $display("FAIL %s R7 R8 preempt: got %0b exp %0b", tag, preempt_o, exp_pre);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got hang exp finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int idx, int val);
    prio_wr_en = 1; prio_wr_idx = IW'(idx); prio_wr_data = 6'(val);
    tick();
    prio_wr_en = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    // R1: reset state, all values zero
    tag = "R1";
    checks++;
    if (win_valid_o !== 0 || preempt_o !== 0 || win_idx_o !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %0b/%0b/%0d exp 0/0/0", win_valid_o, preempt_o, win_idx_o);
    end
    // R5: all values 0 -> index tie-break
    tag = "R5";
    pend_i = 8'b1110_0100; en_i = 8'hFF; tick(2);
    pend_i = 8'b1111_1111; en_i = 8'b1111_0000; tick(2);
    // R3: pending without enable and vice versa
    tag = "R3";
    pend_i = 8'h0F; en_i = 8'hF0; tick(2);
    pend_i = 8'h00; en_i = 8'hFF; tick(2);
    // R2: write then use
    tag = "R2";
    pend_i = 8'hFF;
    for (int i = 0; i < N; i++) wr(i, 40 - i);
    tick(2);
    wr(3, 5); tick(2);
    // R4: random values, random masks
    tag = "R4";
    for (int t = 0; t < 300; t++) begin
      if (t % 5 == 0) wr(int'($urandom_range(0, N-1)), int'($urandom_range(0, 63)));
      pend_i = N'($urandom); en_i = N'($urandom);
      run_active_i = 0;
      tick();
    end
    // R6 R7: grouping sweep with fixed running value
    tag = "R6 R7";
    for (int i = 0; i < N; i++) wr(i, 63);
    wr(2, 6'b011_010);
    pend_i = 8'h04; en_i = 8'hFF;
    run_active_i = 1; run_prio_i = 6'b011_101;
    for (int g = 0; g < 8; g++) begin group_sel_i = 3'(g); tick(2); end
    run_prio_i = 6'b011_010;
    for (int g = 0; g < 8; g++) begin group_sel_i = 3'(g); tick(2); end
    // R7 R8 R9: random everything
    tag = "R7 R8 R9";
    for (int t = 0; t < 600; t++) begin
      if (t % 3 == 0) wr(int'($urandom_range(0, N-1)), int'($urandom_range(0, 63)));
      pend_i = N'($urandom); en_i = N'($urandom);
      group_sel_i = 3'($urandom); run_active_i = 1'($urandom);
      run_prio_i = 6'($urandom);
      tick();
    end
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule